// File: doc/BRIEF.md
# Integer Line Rasterizer

This block turns line segments into the sequence of pixels that a raster line covers. Each segment arrives as a pair of integer pixel coordinates (start and end) over a valid/ready input taken from a queue of pending lines. The block then streams one pixel coordinate per clock over a valid/ready output into a second queue. A separate memory-writer stage drains that queue.

The walk uses only integer additions and comparisons, with no division. A signed decision term tracks how far the ideal line sits from the pixel centre. The axis with the larger extent is the major axis, and it advances by one on every pixel. The other axis, the minor axis, advances only when the decision term says so. Step directions come from the signs of the coordinate differences, so all eight octants are covered. A new segment is accepted only when the previous one has been fully emitted.

Top module: `line_raster`

## Requirements
- R1: After reset `pix_valid_o` is low and `seg_ready_o` is high.
- R2: A segment is taken on a clock where `seg_valid_i` and `seg_ready_o` are both high. `seg_ready_o` stays low while a segment is being emitted, and `seg_valid_i` with any coordinates has no effect on the output stream during that time.
- R3: The cycle after a segment is taken, `pix_valid_o` is high and the output shows the start point. Exactly max(|x1−x0|, |y1−y0|)+1 pixels are emitted, and the final one is the end point.
- R4: `pix_last_o` is high on the final pixel of a segment and on no other. After the final pixel is taken, `pix_valid_o` falls and `seg_ready_o` rises on the next cycle.
- R5: Between consecutive pixels of a segment, each coordinate changes by at most one unit and at least one coordinate changes.
- R6: The pixel sequence follows the integer decision rule. The major axis is y only when |dy| > |dx| strictly; otherwise it is x. Call the major extent M and the minor extent m. The decision term starts at 2m−M. After each pixel, when the term is greater than zero, the minor coordinate steps toward the end point and the term loses 2M. In every case the term then gains 2m, and the major coordinate steps toward the end point.
- R7: A segment whose start equals its end produces one pixel, with `pix_last_o` high.
- R8: While `pix_valid_o` is high and `pix_ready_i` is low, the next cycle shows the same pixel with `pix_valid_o` still high.
- R9: Coordinates are unsigned `CW`-bit integers. Lines that run from any corner of the full coordinate range to any other are rasterized correctly, in both directions on each axis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| seg_valid_i | input | 1 | Segment offered |
| seg_ready_o | output | 1 | Block can take a segment |
| x0_i | input | CW | Start x |
| y0_i | input | CW | Start y |
| x1_i | input | CW | End x |
| y1_i | input | CW | End y |
| pix_valid_o | output | 1 | Pixel coordinate valid |
| pix_ready_i | input | 1 | Downstream queue can take a pixel |
| pix_x_o | output | CW | Pixel x |
| pix_y_o | output | CW | Pixel y |
| pix_last_o | output | 1 | Final pixel of the segment |

## Verification
The hardest case to reach is a stall that lands on the step where the decision term crosses zero, in a steep line that runs toward decreasing coordinates. That is where a held pixel could slip or the minor step could be applied twice. The bench withholds `pix_ready_i` at random on about a quarter of cycles across many random segments in all octants. It also raises `seg_valid_i` with unrelated coordinates during emission. Directed segments of zero length, with equal extents and across the full range, cover the boundaries of the axis choice.

// File: rtl/bres_pkg.sv
package bres_pkg;
  typedef enum logic {AX_X = 1'b0, AX_Y = 1'b1} axis_e;
endpackage

// File: rtl/bres_setup.sv
module bres_setup
  import bres_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic [CW-1:0] x0_i,
  input  logic [CW-1:0] y0_i,
  input  logic [CW-1:0] x1_i,
  input  logic [CW-1:0] y1_i,
  output logic [CW-1:0] major_o,
  output logic [CW-1:0] minor_o,
  output axis_e         axis_o,
  output logic          x_neg_o,
  output logic          y_neg_o
);
  logic [CW:0]   dx, dy;
  logic [CW-1:0] adx, ady;

  assign dx      = {1'b0, x1_i} - {1'b0, x0_i};
  assign dy      = {1'b0, y1_i} - {1'b0, y0_i};
  assign x_neg_o = dx[CW];
  assign y_neg_o = dy[CW];

  always_comb begin
    logic [CW:0] nx, ny;
    nx  = -dx;
    ny  = -dy;
    adx = x_neg_o ? nx[CW-1:0] : dx[CW-1:0];
    ady = y_neg_o ? ny[CW-1:0] : dy[CW-1:0];
  end

  // ties stay x-major
  assign axis_o  = (ady > adx) ? AX_Y : AX_X;
  assign major_o = (axis_o == AX_Y) ? ady : adx;
  assign minor_o = (axis_o == AX_Y) ? adx : ady;
endmodule

// File: rtl/bres_walk.sv
module bres_walk
  import bres_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic [CW-1:0] x0_i,
  input  logic [CW-1:0] y0_i,
  input  logic [CW-1:0] major_i,
  input  logic [CW-1:0] minor_i,
  input  axis_e         axis_i,
  input  logic          x_neg_i,
  input  logic          y_neg_i,
  output logic          busy_o,
  output logic          last_o,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o
);
  localparam int EW = CW + 3;

  logic                 busy_q, xn_q, yn_q;
  axis_e                axis_q;
  logic [CW-1:0]        x_q, y_q, cnt_q;
  logic signed [EW-1:0] err_q, maj2_q, min2_q;
  logic signed [EW-1:0] maj2_in, min2_in, maj_in, err_nxt;
  logic                 minor_step, x_mv, y_mv;

  assign maj_in  = signed'(EW'(major_i));
  assign maj2_in = signed'(EW'({major_i, 1'b0}));
  assign min2_in = signed'(EW'({minor_i, 1'b0}));

  assign minor_step = (err_q > 0);
  assign x_mv       = (axis_q == AX_X) || minor_step;
  assign y_mv       = (axis_q == AX_Y) || minor_step;
  assign err_nxt    = minor_step ? (err_q - maj2_q + min2_q) : (err_q + min2_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      xn_q   <= 1'b0;
      yn_q   <= 1'b0;
      axis_q <= AX_X;
      x_q    <= '0;
      y_q    <= '0;
      cnt_q  <= '0;
      err_q  <= '0;
      maj2_q <= '0;
      min2_q <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      xn_q   <= x_neg_i;
      yn_q   <= y_neg_i;
      axis_q <= axis_i;
      x_q    <= x0_i;
      y_q    <= y0_i;
      cnt_q  <= major_i;
      err_q  <= min2_in - maj_in;
      maj2_q <= maj2_in;
      min2_q <= min2_in;
    end else if (adv_i && busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        err_q <= err_nxt;
        if (x_mv) x_q <= xn_q ? x_q - 1'b1 : x_q + 1'b1;
        if (y_mv) y_q <= yn_q ? y_q - 1'b1 : y_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == '0);
  assign x_o    = x_q;
  assign y_o    = y_q;

  // R5
  unit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && busy_q && !last_o) |=>
      ((CW'(x_q - $past(x_q)) == CW'(0)) || (CW'(x_q - $past(x_q)) == CW'(1)) ||
       (CW'(x_q - $past(x_q)) == '1)) &&
      ((CW'(y_q - $past(y_q)) == CW'(0)) || (CW'(y_q - $past(y_q)) == CW'(1)) ||
       (CW'(y_q - $past(y_q)) == '1)) &&
      ((x_q != $past(x_q)) || (y_q != $past(y_q))));
endmodule

// File: rtl/line_raster.sv
module line_raster
  import bres_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          seg_valid_i,
  output logic          seg_ready_o,
  input  logic [CW-1:0] x0_i,
  input  logic [CW-1:0] y0_i,
  input  logic [CW-1:0] x1_i,
  input  logic [CW-1:0] y1_i,
  output logic          pix_valid_o,
  input  logic          pix_ready_i,
  output logic [CW-1:0] pix_x_o,
  output logic [CW-1:0] pix_y_o,
  output logic          pix_last_o
);
  logic [CW-1:0] major, minor;
  axis_e         axis;
  logic          x_neg, y_neg, busy, seg_fire, pix_fire;

  assign seg_ready_o = !busy;
  assign seg_fire    = seg_valid_i && seg_ready_o;
  assign pix_valid_o = busy;
  assign pix_fire    = busy && pix_ready_i;

  bres_setup #(.CW(CW)) u_setup (
    .x0_i    (x0_i),
    .y0_i    (y0_i),
    .x1_i    (x1_i),
    .y1_i    (y1_i),
    .major_o (major),
    .minor_o (minor),
    .axis_o  (axis),
    .x_neg_o (x_neg),
    .y_neg_o (y_neg)
  );

  bres_walk #(.CW(CW)) u_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (seg_fire),
    .adv_i   (pix_fire),
    .x0_i    (x0_i),
    .y0_i    (y0_i),
    .major_i (major),
    .minor_i (minor),
    .axis_i  (axis),
    .x_neg_i (x_neg),
    .y_neg_i (y_neg),
    .busy_o  (busy),
    .last_o  (pix_last_o),
    .x_o     (pix_x_o),
    .y_o     (pix_y_o)
  );

  // R3
  load_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_fire |=> pix_valid_o && (pix_x_o == $past(x0_i)) && (pix_y_o == $past(y0_i)));

  // R4
  last_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_fire && pix_last_o) |=> (!pix_valid_o && seg_ready_o));

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && !pix_ready_i) |=>
      (pix_valid_o && $stable(pix_x_o) && $stable(pix_y_o) && $stable(pix_last_o)));

  // R2
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && !(pix_fire && pix_last_o) && seg_valid_i) |=> pix_valid_o);
endmodule

// File: tb/line_raster_bench.sv
module line_raster_bench;
  localparam int CW   = 10;
  localparam int SPAN = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          seg_valid = 1'b0;
  logic          seg_ready;
  logic [CW-1:0] x0 = '0, y0 = '0, x1 = '0, y1 = '0;
  logic          pix_valid;
  logic          pix_ready = 1'b0;
  logic [CW-1:0] pix_x, pix_y;
  logic          pix_last;

  int checks = 0;
  int failures = 0;
  int ex[0:SPAN-1];
  int ey[0:SPAN-1];

  always #10 clk = ~clk;

  line_raster #(.CW(CW)) u_line_raster (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .seg_valid_i (seg_valid),
    .seg_ready_o (seg_ready),
    .x0_i        (x0),
    .y0_i        (y0),
    .x1_i        (x1),
    .y1_i        (y1),
    .pix_valid_o (pix_valid),
    .pix_ready_i (pix_ready),
    .pix_x_o     (pix_x),
    .pix_y_o     (pix_y),
    .pix_last_o  (pix_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected pixel list from the decision rule of R6
  task automatic build(input int ax0, input int ay0, input int ax1, input int ay1,
                       output int n);
    int dx, dy, sx, sy, adx, ady, mj, mn, e, x, y;
    bit steep;
    dx = ax1 - ax0; dy = ay1 - ay0;
    sx = (dx < 0) ? -1 : 1; sy = (dy < 0) ? -1 : 1;
    adx = (dx < 0) ? -dx : dx; ady = (dy < 0) ? -dy : dy;
    steep = ady > adx;
    mj = steep ? ady : adx; mn = steep ? adx : ady;
    e = 2 * mn - mj; x = ax0; y = ay0;
    for (int k = 0; k <= mj; k++) begin
      ex[k] = x; ey[k] = y;
      if (e > 0) begin
        if (steep) x += sx; else y += sy;
        e -= 2 * mj;
      end
      e += 2 * mn;
      if (steep) y += sy; else x += sx;
    end
    n = mj + 1;
  endtask

  task automatic run_seg(input int a, input int b, input int c, input int d,
                         input bit junk, input string tag);
    int n, idx, px, py;
    bit done, pv, pr, rdy;
    build(a, b, c, d, n);
    @(negedge clk);
    chk(seg_ready == 1'b1, {tag, "/R2 idle ready"}, seg_ready, 1);
    seg_valid = 1'b1;
    x0 = CW'(a); y0 = CW'(b); x1 = CW'(c); y1 = CW'(d);
    @(negedge clk);
    seg_valid = 1'b0;
    idx = 0; done = 0; pv = 0; pr = 0; px = 0; py = 0;
    while (!done) begin
      if (pv && !pr) begin
        chk(pix_valid && pix_x == CW'(px) && pix_y == CW'(py), {tag, "/R8 stall hold x"},
            int'(pix_x), px);
      end
      chk(pix_valid == 1'b1, {tag, "/R3 valid during segment"}, pix_valid, 1);
      chk(seg_ready == 1'b0, {tag, "/R2 busy not ready"}, seg_ready, 0);
      rdy = ($urandom % 4) != 0;
      pix_ready = rdy;
      if (junk && !(rdy && idx == n - 1)) begin
        seg_valid = 1'b1;
        x0 = CW'($urandom); y0 = CW'($urandom); x1 = CW'($urandom); y1 = CW'($urandom);
      end else begin
        seg_valid = 1'b0;
      end
      if (rdy) begin
        chk(int'(pix_x) == ex[idx], {tag, "/R6 pixel x"}, int'(pix_x), ex[idx]);
        chk(int'(pix_y) == ey[idx], {tag, "/R6 pixel y"}, int'(pix_y), ey[idx]);
        chk(pix_last == (idx == n - 1), {tag, "/R4 last flag"}, pix_last, int'(idx == n - 1));
        idx++;
        if (idx == n) done = 1;
      end
      pv = 1; pr = rdy; px = int'(pix_x); py = int'(pix_y);
      @(negedge clk);
    end
    pix_ready = 1'b0;
    seg_valid = 1'b0;
    chk(pix_valid == 1'b0, {tag, "/R3 count ends"}, pix_valid, 0);
    chk(seg_ready == 1'b1, {tag, "/R4 ready after last"}, seg_ready, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1
    chk(pix_valid == 1'b0, "R1 valid in reset", pix_valid, 0);
    chk(seg_ready == 1'b1, "R1 ready in reset", seg_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pix_valid == 1'b0 && seg_ready == 1'b1, "R1 after reset", pix_valid, 0);

    run_seg(100, 200, 100, 200, 0, "R7 zero length");
    run_seg(5, 7, 20, 7, 0, "R6 horizontal +x");
    run_seg(20, 7, 5, 7, 1, "R6 horizontal -x");
    run_seg(9, 3, 9, 30, 0, "R6 vertical +y");
    run_seg(9, 30, 9, 3, 1, "R6 vertical -y");
    run_seg(10, 10, 25, 25, 0, "R6 tie diagonal");
    run_seg(40, 40, 30, 50, 0, "R6 anti diagonal");
    run_seg(50, 50, 47, 60, 1, "R5 steep -x");
    run_seg(50, 60, 57, 41, 0, "R5 steep -y");
    run_seg(0, 0, SPAN - 1, SPAN - 1, 0, "R9 corner up");
    run_seg(SPAN - 1, 0, 0, 5, 0, "R9 shallow left");
    run_seg(3, SPAN - 1, 0, 0, 1, "R9 steep down");

    for (int s = 0; s < 150; s++) begin
      int a, b, c, d;
      a = $urandom % SPAN; b = $urandom % SPAN;
      c = a + int'($urandom % 161) - 80; d = b + int'($urandom % 161) - 80;
      if (c < 0) c = 0; if (c > SPAN - 1) c = SPAN - 1;
      if (d < 0) d = 0; if (d > SPAN - 1) d = SPAN - 1;
      run_seg(a, b, c, d, ($urandom % 2) == 1, "R6 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule